// File: doc/BRIEF.md
# Blocked Matrix Layout Converter

This block copies a row-major matrix from a source memory port to a destination memory port and rearranges it into square tiles of `BLK` × `BLK` elements. Two independent choices set the arrangement: the order in which tiles are visited, either across tile rows or down tile columns, and the order of the elements inside each tile, either row by row or column by column. Where the matrix height or width is not a multiple of `BLK`, the missing positions of the edge tiles are filled with zeros. The destination is densely packed, so every tile takes `BLK*BLK` consecutive words.

A controller raises `start` for one cycle while the dimensions, the mode and both base addresses are valid. The block captures these values and then issues one element per cycle. The source port has a read latency of one cycle. Positions that fall in the padding issue no source read. `done` pulses once the last word has been written.

Top module: `tile_reorder_mover`

## Requirements
- R1: A `start` seen while `busy` is low is accepted. If both dimensions are nonzero, `busy` is high in the following cycle. Dimensions, mode and base addresses are captured when the start is accepted.
- R2: With `modeIn` = 0, tiles are visited left to right along a tile row, and tile rows top to bottom. Inside each tile, elements are stored row by row.
- R3: With `modeIn` = 1, tiles are visited in the same order as mode 0. Inside each tile, elements are stored column by column.
- R4: With `modeIn` = 2, tiles are visited top to bottom along a tile column, and tile columns left to right. Inside each tile, elements are stored row by row. Bit 1 of the mode selects the tile order and bit 0 selects the order inside a tile, independently of each other.
- R5: With `modeIn` = 3, tiles are visited in column order and elements inside each tile are stored column by column.
- R6: A position whose row is at or beyond `rowsIn`, or whose column is at or beyond `colsIn`, is written as zero and issues no source read. A job therefore issues exactly rows × cols source reads. Element (r, c) is read from `srcBase + r*cols + c`.
- R7: Destination addresses start at `dstBaseIn` and rise by one on every write. A job writes exactly ceil(rows/BLK) × ceil(cols/BLK) × BLK² words.
- R8: Each destination write occurs in the cycle after its source slot was issued. The data of a read arrives on `srcRdData` in the cycle after `srcRdEn`.
- R9: `done` is high for exactly one cycle, in the cycle after the last destination write. `busy` is low in that cycle.
- R10: A `start` seen while `busy` is high has no effect on the running job.
- R11: A start with zero rows or zero columns raises `done` in the next cycle, with no reads and no writes.
- R12: After reset, `busy`, `done`, `srcRdEn` and `dstWrEn` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Job request pulse |
| rowsIn | input | DIM_W | Matrix height in elements |
| colsIn | input | DIM_W | Matrix width in elements |
| modeIn | input | 2 | Bit 1: tile order by columns; bit 0: element order inside a tile by columns |
| srcBaseIn | input | ADDR_W | Source word address of element (0,0) |
| dstBaseIn | input | ADDR_W | First destination word address |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| srcRdEn | output | 1 | Source read strobe |
| srcAddr | output | ADDR_W | Source read address |
| srcRdData | input | DATA_W | Source read data, one cycle after the strobe |
| dstWrEn | output | 1 | Destination write strobe |
| dstAddr | output | ADDR_W | Destination write address |
| dstWrData | output | DATA_W | Destination write data |

## Verification
The bound assertions check every cycle that destination addresses rise by one across back-to-back writes, that each read is followed by a write in the next cycle, and that no strobe occurs outside a job. They also check that `busy` only falls together with `done`, and that an accepted start leads to `busy` or `done`. The exact element order for each of the four modes, the zero-fill values of edge tiles and the number of source reads can only be shown by the bench, which compares every written word against a model of the tile order. The same applies to rejecting a start during a job and to the zero-dimension case.

// File: rtl/tile_pkg.sv
package tile_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;   // capture job parameters and clear the walkers
    logic issue;  // emit one element slot this cycle
  } tileCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } tileState_t;

  // modeIn bit meanings
  localparam int MODE_OUTER_COL = 1;  // tiles walked down columns
  localparam int MODE_INNER_COL = 0;  // elements walked down columns

endpackage

// File: rtl/tile_ctrl.sv
module tile_ctrl
  import tile_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     zeroDim,
  input  logic     lastIssue,
  output tileCtl_t ctl,
  output logic     busy,
  output logic     done
);

  tileState_t state, stateNext;

  always_comb begin
    stateNext = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        stateNext = ST_IDLE;
        if (start) begin
          if (zeroDim) begin
            stateNext = ST_DONE;
          end else begin
            ctl.load  = 1'b1;
            stateNext = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        ctl.issue = 1'b1;
        if (lastIssue) stateNext = ST_DRAIN;
      end
      ST_DRAIN: stateNext = ST_DONE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state == ST_RUN) || (state == ST_DRAIN);
  assign done = (state == ST_DONE);

endmodule

// File: rtl/tile_dpath.sv
module tile_dpath
  import tile_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int DIM_W  = 8,
  parameter int BLK    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  tileCtl_t          ctl,
  input  logic [DIM_W-1:0]  rowsIn,
  input  logic [DIM_W-1:0]  colsIn,
  input  logic [1:0]        modeIn,
  input  logic [ADDR_W-1:0] srcBaseIn,
  input  logic [ADDR_W-1:0] dstBaseIn,
  output logic              zeroDim,
  output logic              lastIssue,
  output logic              srcRdEn,
  output logic [ADDR_W-1:0] srcAddr,
  input  logic [DATA_W-1:0] srcRdData,
  output logic              dstWrEn,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [DATA_W-1:0] dstWrData
);

  localparam int BLK_W = (BLK > 1) ? $clog2(BLK) : 1;
  localparam int POS_W = DIM_W + BLK_W;
  localparam logic [BLK_W-1:0] BLK_MAX = BLK_W'(BLK - 1);

  // captured job parameters
  logic [DIM_W-1:0]  rowsQ, colsQ, tileRowsQ, tileColsQ;
  logic [1:0]        modeQ;
  logic [ADDR_W-1:0] srcBaseQ, dstPtr;

  // nested walkers: inner tile position and tile position, fast and slow
  logic [BLK_W-1:0] inFast, inSlow;
  logic [DIM_W-1:0] outFast, outSlow;

  // write stage
  logic              wrEnQ, wrPadQ;
  logic [ADDR_W-1:0] wrAddrQ;

  // tile counts from the requested dimensions (ceiling division)
  logic [DIM_W:0] rowsRound, colsRound;
  logic [DIM_W-1:0] tileRowsNext, tileColsNext;
  always_comb begin
    rowsRound    = {1'b0, rowsIn} + (DIM_W+1)'(BLK - 1);
    colsRound    = {1'b0, colsIn} + (DIM_W+1)'(BLK - 1);
    tileRowsNext = DIM_W'(rowsRound / (DIM_W+1)'(BLK));
    tileColsNext = DIM_W'(colsRound / (DIM_W+1)'(BLK));
  end

  assign zeroDim = (rowsIn == '0) || (colsIn == '0);

  // walker limits for the selected tile order
  logic [DIM_W-1:0] nFast, nSlow;
  logic innerFastEnd, innerSlowEnd, outerFastEnd, outerSlowEnd;
  always_comb begin
    nFast        = modeQ[MODE_OUTER_COL] ? tileRowsQ : tileColsQ;
    nSlow        = modeQ[MODE_OUTER_COL] ? tileColsQ : tileRowsQ;
    innerFastEnd = (inFast == BLK_MAX);
    innerSlowEnd = (inSlow == BLK_MAX);
    outerFastEnd = (outFast == nFast - DIM_W'(1));
    outerSlowEnd = (outSlow == nSlow - DIM_W'(1));
    lastIssue    = innerFastEnd && innerSlowEnd && outerFastEnd && outerSlowEnd;
  end

  // map walkers to matrix coordinates
  logic [BLK_W-1:0] inRow, inCol;
  logic [DIM_W-1:0] tileRow, tileCol;
  logic [POS_W-1:0] rowPos, colPos;
  logic             inRange;
  always_comb begin
    inRow   = modeQ[MODE_INNER_COL] ? inFast  : inSlow;
    inCol   = modeQ[MODE_INNER_COL] ? inSlow  : inFast;
    tileRow = modeQ[MODE_OUTER_COL] ? outFast : outSlow;
    tileCol = modeQ[MODE_OUTER_COL] ? outSlow : outFast;
    rowPos  = POS_W'(tileRow) * POS_W'(BLK) + POS_W'(inRow);
    colPos  = POS_W'(tileCol) * POS_W'(BLK) + POS_W'(inCol);
    inRange = (rowPos < POS_W'(rowsQ)) && (colPos < POS_W'(colsQ));
  end

  assign srcRdEn = ctl.issue && inRange;
  assign srcAddr = srcBaseQ + ADDR_W'(rowPos) * ADDR_W'(colsQ) + ADDR_W'(colPos);

  // parameter capture and walker advance
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowsQ     <= '0;
      colsQ     <= '0;
      tileRowsQ <= '0;
      tileColsQ <= '0;
      modeQ     <= '0;
      srcBaseQ  <= '0;
      dstPtr    <= '0;
      inFast    <= '0;
      inSlow    <= '0;
      outFast   <= '0;
      outSlow   <= '0;
    end else if (ctl.load) begin
      rowsQ     <= rowsIn;
      colsQ     <= colsIn;
      tileRowsQ <= tileRowsNext;
      tileColsQ <= tileColsNext;
      modeQ     <= modeIn;
      srcBaseQ  <= srcBaseIn;
      dstPtr    <= dstBaseIn;
      inFast    <= '0;
      inSlow    <= '0;
      outFast   <= '0;
      outSlow   <= '0;
    end else if (ctl.issue) begin
      dstPtr <= dstPtr + ADDR_W'(1);
      if (!innerFastEnd) begin
        inFast <= inFast + BLK_W'(1);
      end else begin
        inFast <= '0;
        if (!innerSlowEnd) begin
          inSlow <= inSlow + BLK_W'(1);
        end else begin
          inSlow <= '0;
          if (!outerFastEnd) begin
            outFast <= outFast + DIM_W'(1);
          end else begin
            outFast <= '0;
            outSlow <= outSlow + DIM_W'(1);
          end
        end
      end
    end
  end

  // one-stage write pipe matching the source read latency
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrEnQ   <= 1'b0;
      wrPadQ  <= 1'b0;
      wrAddrQ <= '0;
    end else begin
      wrEnQ  <= ctl.issue;
      wrPadQ <= ctl.issue && !inRange;
      if (ctl.issue) wrAddrQ <= dstPtr;
    end
  end

  assign dstWrEn   = wrEnQ;
  assign dstAddr   = wrAddrQ;
  assign dstWrData = wrPadQ ? '0 : srcRdData;

endmodule

// File: rtl/tile_reorder_mover.sv
module tile_reorder_mover
  import tile_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int DIM_W  = 8,
  parameter int BLK    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DIM_W-1:0]  rowsIn,
  input  logic [DIM_W-1:0]  colsIn,
  input  logic [1:0]        modeIn,
  input  logic [ADDR_W-1:0] srcBaseIn,
  input  logic [ADDR_W-1:0] dstBaseIn,
  output logic              busy,
  output logic              done,
  output logic              srcRdEn,
  output logic [ADDR_W-1:0] srcAddr,
  input  logic [DATA_W-1:0] srcRdData,
  output logic              dstWrEn,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [DATA_W-1:0] dstWrData
);

  tileCtl_t ctl;
  logic     zeroDim, lastIssue;

  tile_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .zeroDim   (zeroDim),
    .lastIssue (lastIssue),
    .ctl       (ctl),
    .busy      (busy),
    .done      (done)
  );

  tile_dpath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .DIM_W  (DIM_W),
    .BLK    (BLK)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .rowsIn    (rowsIn),
    .colsIn    (colsIn),
    .modeIn    (modeIn),
    .srcBaseIn (srcBaseIn),
    .dstBaseIn (dstBaseIn),
    .zeroDim   (zeroDim),
    .lastIssue (lastIssue),
    .srcRdEn   (srcRdEn),
    .srcAddr   (srcAddr),
    .srcRdData (srcRdData),
    .dstWrEn   (dstWrEn),
    .dstAddr   (dstAddr),
    .dstWrData (dstWrData)
  );

endmodule

// File: rtl/tile_reorder_checks.sv
module tile_reorder_checks #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              srcRdEn,
  input logic              dstWrEn,
  input logic [ADDR_W-1:0] dstAddr
);

  p_start_taken_r1: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy |=> busy || done);

  p_read_in_job_r6: assert property (@(posedge clk) disable iff (!rstN)
    srcRdEn |-> busy);

  p_dst_packed_r7: assert property (@(posedge clk) disable iff (!rstN)
    dstWrEn && $past(dstWrEn) |-> dstAddr == $past(dstAddr) + ADDR_W'(1));

  p_read_then_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    srcRdEn |=> dstWrEn);

  p_no_write_at_launch_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !dstWrEn);

  p_write_in_job_r8: assert property (@(posedge clk) disable iff (!rstN)
    dstWrEn |-> busy);

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && !dstWrEn && !srcRdEn);

  p_busy_ends_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

endmodule

bind tile_reorder_mover tile_reorder_checks #(.ADDR_W(ADDR_W)) u_checks (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .srcRdEn (srcRdEn),
  .dstWrEn (dstWrEn),
  .dstAddr (dstAddr)
);

// File: tb/test_tile_reorder_mover.sv
module test_tile_reorder_mover;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 10;
  localparam int DIM_W  = 6;
  localparam int BLK    = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [DIM_W-1:0]  rowsIn = '0;
  logic [DIM_W-1:0]  colsIn = '0;
  logic [1:0]        modeIn = '0;
  logic [ADDR_W-1:0] srcBaseIn = '0;
  logic [ADDR_W-1:0] dstBaseIn = '0;
  logic              busy, done, srcRdEn, dstWrEn;
  logic [ADDR_W-1:0] srcAddr, dstAddr;
  logic [DATA_W-1:0] srcRdData = '0;
  logic [DATA_W-1:0] dstWrData;

  always #(CLK_PERIOD/2) clk = ~clk;

  tile_reorder_mover #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .DIM_W  (DIM_W),
    .BLK    (BLK)
  ) i_tile_reorder_mover (
    .clk (clk), .rstN (rstN), .start (start),
    .rowsIn (rowsIn), .colsIn (colsIn), .modeIn (modeIn),
    .srcBaseIn (srcBaseIn), .dstBaseIn (dstBaseIn),
    .busy (busy), .done (done),
    .srcRdEn (srcRdEn), .srcAddr (srcAddr), .srcRdData (srcRdData),
    .dstWrEn (dstWrEn), .dstAddr (dstAddr), .dstWrData (dstWrData)
  );

  // source memory model: word at address a holds 0x8000 + a, one-cycle read
  function automatic logic [DATA_W-1:0] srcWord(input int a);
    return DATA_W'(16'h8000 + (a % (1 << ADDR_W)));
  endfunction

  always @(posedge clk) begin
    if (srcRdEn) srcRdData <= srcWord(int'(srcAddr));
  end

  int rdCount = 0;
  always @(posedge clk) begin
    if (rstN && srcRdEn) rdCount <= rdCount + 1;
  end

  int checks = 0;
  int fails  = 0;
  string curReq = "R2";

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  typedef struct {
    int addr;
    int data;
  } wrItem_t;

  wrItem_t expQ[$];

  // monitor: compare every destination write with the scoreboard
  always @(negedge clk) begin
    if (rstN && dstWrEn) begin
      if (expQ.size() == 0) begin
        check(1'b0, curReq, "unexpected write addr", int'(dstAddr), -1);
      end else begin
        wrItem_t it;
        it = expQ.pop_front();
        check(int'(dstAddr) == it.addr, curReq, "dst address", int'(dstAddr), it.addr);
        check(int'(dstWrData) == it.data, curReq, "dst data", int'(dstWrData), it.data);
      end
    end
  end

  // driver: build the expected stream from the tile-order rules, then launch
  task automatic runJob(input int rows, input int cols, input int mode,
                        input int sb, input int db, input string req,
                        input bit pokeBusy);
    int tr, tc, nFast, nSlow, k;
    int waitCnt;
    tr = (rows + BLK - 1) / BLK;
    tc = (cols + BLK - 1) / BLK;
    nFast = mode[1] ? tr : tc;
    nSlow = mode[1] ? tc : tr;
    k = 0;
    curReq = req;
    if (rows != 0 && cols != 0) begin
      for (int s = 0; s < nSlow; s++) begin
        for (int f = 0; f < nFast; f++) begin
          for (int a = 0; a < BLK; a++) begin
            for (int b = 0; b < BLK; b++) begin
              int br, bc, ir, ic, r, c;
              wrItem_t it;
              br = mode[1] ? f : s;
              bc = mode[1] ? s : f;
              ir = mode[0] ? b : a;
              ic = mode[0] ? a : b;
              r = br * BLK + ir;
              c = bc * BLK + ic;
              it.addr = (db + k) % (1 << ADDR_W);
              it.data = (r < rows && c < cols) ? int'(srcWord(sb + r * cols + c)) : 0;
              expQ.push_back(it);
              k++;
            end
          end
        end
      end
    end
    @(negedge clk);
    rdCount   = 0;
    rowsIn    = DIM_W'(rows);
    colsIn    = DIM_W'(cols);
    modeIn    = 2'(mode);
    srcBaseIn = ADDR_W'(sb);
    dstBaseIn = ADDR_W'(db);
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (rows == 0 || cols == 0) begin
      check(done == 1'b1, "R11", "done after empty start", int'(done), 1);
      check(busy == 1'b0, "R11", "busy after empty start", int'(busy), 0);
    end else begin
      check(busy == 1'b1, "R1", "busy after start", int'(busy), 1);
    end
    if (pokeBusy) begin
      repeat (5) @(negedge clk);
      rowsIn = DIM_W'(2);
      colsIn = DIM_W'(3);
      modeIn = 2'(3 - mode);
      dstBaseIn = ADDR_W'(0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R10", "busy kept after start in job", int'(busy), 1);
    end
    waitCnt = 0;
    while (!done && waitCnt < 5000) begin
      @(negedge clk);
      waitCnt++;
    end
    check(done == 1'b1, req, "done reached", int'(done), 1);
    check(busy == 1'b0, "R9", "busy low with done", int'(busy), 0);
    check(expQ.size() == 0, "R7", "writes missing at done", expQ.size(), 0);
    check(rdCount == rows * cols, "R6", "source read count", rdCount, rows * cols);
    expQ.delete();
    @(negedge clk);
    check(done == 1'b0, "R9", "done single cycle", int'(done), 0);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, curReq, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: outputs quiet under and after reset
    check(busy == 1'b0 && done == 1'b0, "R12", "busy|done in reset", int'(busy | done), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(srcRdEn == 1'b0 && dstWrEn == 1'b0, "R12", "strobes after reset",
          int'(srcRdEn | dstWrEn), 0);
    check(busy == 1'b0, "R12", "busy after reset", int'(busy), 0);

    runJob(8, 8, 0, 0,   100, "R2", 1'b0);  // full tiles, row/row
    runJob(6, 7, 0, 64,  300, "R6", 1'b0);  // padding in both directions
    runJob(5, 9, 1, 10,  500, "R3", 1'b0);  // column order inside tiles
    runJob(7, 6, 2, 200, 40,  "R4", 1'b0);  // tiles walked by columns
    runJob(9, 5, 3, 300, 700, "R5", 1'b0);  // both column orders
    runJob(3, 2, 1, 5,   1020, "R7", 1'b0); // single partial tile, dst wraps
    runJob(0, 5, 0, 0,   0,   "R11", 1'b0); // zero rows
    runJob(4, 0, 2, 0,   0,   "R11", 1'b0); // zero cols
    runJob(10, 11, 2, 400, 600, "R10", 1'b1); // start while busy ignored
    runJob(1, 1, 3, 900, 8,   "R8", 1'b0);  // one element, read latency
    finishRun();
  end

endmodule